// File: doc/BRIEF.md
# Serial Command and Fault Status Front End

This block is the serial slave front end of a 16-channel low-side output controller. A host talks to it over a four-wire SPI link with 24-bit frames, most significant bit first in both directions. Each frame carries a 6-bit command code and 16 per-output data bits. When chip select goes high, the frame is decoded and one control register is updated: the output on/off state, open-load current enable, short-fault fast-shutdown disable, PWM enable, PWM AND/OR combining, or the global retry policy. A soft reset command clears part of the register set.

While the host clocks in a command, the block shifts out a 24-bit fault status word. The word is captured when chip select falls. The status word holds a summary bit, an overvoltage bit and one latched fault per output. All latched faults are cleared when chip select rises. The shift path behaves as a plain 24-bit FIFO, so devices can be chained and a 48-bit echo test can confirm link integrity.

The SPI pins are brought into the system clock domain by two-stage synchronizers, and every edge is detected there. The serial clock must therefore run well below the system clock. Analog fault sensing lies outside this block and delivers its results as per-output flags.

Top module: `spi_cmd_status_if`

## Requirements
- R1: After power-on reset, while `rst_pin_n` is low or while `supply_uv` is high, every control register, both retry bits and all latched faults are zero.
- R2: MOSI is sampled on each falling SCLK edge while selected, MSB first. On the rising edge of chip select, bits 23..18 choose the target and bits 15..0 are written to it. The codes are 0 = on/off, 1 = open-load enable, 3 = fast-shutdown disable, 4 = PWM enable, 5 = AND/OR.
- R3: MISO changes only after a rising SCLK edge or the falling edge of chip select. The status word leaves MSB first: the bit available after the k-th rising edge is bit 24-k.
- R4: While chip select is high, MISO output enable is low and SCLK and MOSI have no effect on any register.
- R5: The status word loaded at the falling edge of chip select is {any, ov, 6'b0, fault[15:0]}. Here any is the OR of the overvoltage flag and all output faults.
- R6: At the rising edge of chip select, all latched output faults and the latched overvoltage flag clear. This clear takes priority over a fault present in the same cycle.
- R7: Code 2 loads thermal retry from bit 17 and overvoltage resume from bit 16. Its bits 15..0 are ignored.
- R8: Code 6 clears on/off, fast-shutdown disable, PWM enable and AND/OR. It leaves open-load enable and both retry bits unchanged.
- R9: In a 48-bit frame, the second 24 bits read on MISO equal the first 24 bits written on MOSI, and the last 24 bits written are executed.
- R10: Codes 7 to 63 change no register.
- R11: A frame whose length is not 24 bits executes the shift register contents at chip select rise. These are the last 24 bits shifted, with status bits filling in for a short frame.
- R12: A high `fault_in[i]` or `ov_in` for one cycle sets the matching latched flag. The flag holds until chip select rises or a hard clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Synchronous reset pin, active low, clears all state |
| supply_uv | input | 1 | Supply undervoltage flag, clears all state while high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out |
| spi_miso_oe | output | 1 | Output enable for MISO pad, high while selected |
| fault_in | input | 16 | Per-output fault flags from sensing |
| ov_in | input | 1 | Overvoltage flag from supply monitor |
| out_on | output | 16 | On/off control register |
| out_olen | output | 16 | Open-load current enable register |
| out_sfpd | output | 16 | Fast-shutdown disable register |
| out_pwmen | output | 16 | PWM enable register |
| out_andor | output | 16 | PWM combine register, 1 = OR, 0 = AND |
| retry_therm | output | 1 | Thermal retry policy bit |
| resume_ov | output | 1 | Overvoltage resume policy bit |
| fault_lat | output | 16 | Latched per-output faults |

## Verification
A table of single 24-bit frames writes every command code with distinct bit patterns. Each frame is followed by a readback of one register, which separates a wrong decode from a wrong bit order. The table also sends code 2 with data bits set, to show that only bits 17 and 16 are taken, and two unassigned codes, which must leave earlier values in place. Directed frames then cover the following:
- A soft reset, checked against the registers it must keep.
- A fault status readout, followed by a second read that shows the clear.
- A 48-bit echo frame.
- 30-bit and 16-bit frames that expose which bits get executed.
- SCLK activity with chip select high.
- Hard clears from the reset pin and from undervoltage.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
    localparam int FRAME_W     = 24;
    localparam int NOUT        = 16;
    localparam int CMD_W       = 6;
    localparam int SYNC_STAGES = 2;
    localparam int CMD_LSB     = FRAME_W - CMD_W;
    localparam int PAD_W       = FRAME_W - NOUT - 2;

    localparam logic [CMD_W-1:0] CMD_ONOFF = 6'd0;
    localparam logic [CMD_W-1:0] CMD_OLEN  = 6'd1;
    localparam logic [CMD_W-1:0] CMD_RETRY = 6'd2;
    localparam logic [CMD_W-1:0] CMD_SFPD  = 6'd3;
    localparam logic [CMD_W-1:0] CMD_PWMEN = 6'd4;
    localparam logic [CMD_W-1:0] CMD_ANDOR = 6'd5;
    localparam logic [CMD_W-1:0] CMD_SOFT  = 6'd6;

    typedef struct packed {
        logic [NOUT-1:0] onoff;
        logic [NOUT-1:0] olen;
        logic [NOUT-1:0] sfpd;
        logic [NOUT-1:0] pwmen;
        logic [NOUT-1:0] andor;
        logic            retry_therm;
        logic            resume_ov;
    } ctrl_regs_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_fall,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] status_word,
    output logic               miso,
    output logic [FRAME_W-1:0] word
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic               miso;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cs_fall) begin
            s_d.sh   = status_word;
            s_d.miso = status_word[FRAME_W-1];
        end else begin
            if (sclk_rise) s_d.miso = s_q.sh[FRAME_W-1];
            if (sclk_fall) s_d.sh   = {s_q.sh[FRAME_W-2:0], mosi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign miso = s_q.miso;
    assign word = s_q.sh;

    // R3: MISO moves only on a rising SCLK edge or on capture
    p_miso_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !cs_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hard_clr,
    input  logic               exec,
    input  logic [FRAME_W-1:0] word,
    output ctrl_regs_t         regs
);
    ctrl_regs_t regs_d, regs_q;
    logic [CMD_W-1:0] cmd;
    logic [NOUT-1:0]  data;

    assign cmd  = word[FRAME_W-1:CMD_LSB];
    assign data = word[NOUT-1:0];

    always_comb begin
        regs_d = regs_q;
        if (hard_clr) begin
            regs_d = '0;
        end else if (exec) begin
            case (cmd)
                CMD_ONOFF: regs_d.onoff = data;
                CMD_OLEN:  regs_d.olen  = data;
                CMD_RETRY: begin
                    regs_d.retry_therm = word[NOUT+1];
                    regs_d.resume_ov   = word[NOUT];
                end
                CMD_SFPD:  regs_d.sfpd  = data;
                CMD_PWMEN: regs_d.pwmen = data;
                CMD_ANDOR: regs_d.andor = data;
                CMD_SOFT: begin
                    regs_d.onoff = '0;
                    regs_d.sfpd  = '0;
                    regs_d.pwmen = '0;
                    regs_d.andor = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R1: a hard clear leaves every register at zero
    p_hard_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (regs_q == '0));
    // R2: registers only move when a frame executes
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec && !hard_clr) |=> $stable(regs_q));
    // R10: unassigned codes change nothing
    p_unknown_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !hard_clr && cmd > CMD_SOFT) |=> $stable(regs_q));
    // R8: soft reset keeps open-load enable and retry policy
    p_soft_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !hard_clr && cmd == CMD_SOFT) |=>
        ($stable(regs_q.olen) && $stable(regs_q.retry_therm) &&
         $stable(regs_q.resume_ov) && regs_q.onoff == '0 && regs_q.pwmen == '0));
endmodule

// File: rtl/spi_cmd_status_if.sv
module spi_cmd_status_if
    import spi_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_pin_n,
    input  logic            supply_uv,
    input  logic            spi_cs_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    output logic            spi_miso,
    output logic            spi_miso_oe,
    input  logic [NOUT-1:0] fault_in,
    input  logic            ov_in,
    output logic [NOUT-1:0] out_on,
    output logic [NOUT-1:0] out_olen,
    output logic [NOUT-1:0] out_sfpd,
    output logic [NOUT-1:0] out_pwmen,
    output logic [NOUT-1:0] out_andor,
    output logic            retry_therm,
    output logic            resume_ov,
    output logic [NOUT-1:0] fault_lat
);
    typedef struct packed {
        logic            cs_prev;
        logic            sclk_prev;
        logic [NOUT-1:0] fault;
        logic            ov;
    } top_t;

    top_t t_d, t_q;
    logic cs_lvl, sclk_lvl, mosi_lvl;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall, hard_clr, any_fault;
    logic [FRAME_W-1:0] status_word, rx_word;
    ctrl_regs_t regs;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst_n(rst_n), .pin(spi_cs_n), .level(cs_lvl));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
        .clk(clk), .rst_n(rst_n), .pin(spi_sclk), .level(sclk_lvl));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
        .clk(clk), .rst_n(rst_n), .pin(spi_mosi), .level(mosi_lvl));

    assign hard_clr  = !rst_pin_n || supply_uv;
    assign cs_fall   = t_q.cs_prev && !cs_lvl;
    assign cs_rise   = !t_q.cs_prev && cs_lvl;
    assign sclk_rise = !cs_lvl && sclk_lvl && !t_q.sclk_prev;
    assign sclk_fall = !cs_lvl && !sclk_lvl && t_q.sclk_prev;

    assign any_fault   = (|t_q.fault) || t_q.ov;
    assign status_word = {any_fault, t_q.ov, {PAD_W{1'b0}}, t_q.fault};

    always_comb begin
        t_d           = t_q;
        t_d.cs_prev   = cs_lvl;
        t_d.sclk_prev = sclk_lvl;
        if (hard_clr || cs_rise) begin
            t_d.fault = '0;
            t_d.ov    = 1'b0;
        end else begin
            t_d.fault = t_q.fault | fault_in;
            t_d.ov    = t_q.ov | ov_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{cs_prev: 1'b1, sclk_prev: 1'b0, fault: '0, ov: 1'b0};
        else        t_q <= t_d;
    end

    spi_frame_shifter i_shifter (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .mosi(mosi_lvl), .status_word(status_word),
        .miso(spi_miso), .word(rx_word));

    spi_ctrl_regs i_regs (
        .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr), .exec(cs_rise),
        .word(rx_word), .regs(regs));

    assign spi_miso_oe = !cs_lvl;
    assign out_on      = regs.onoff;
    assign out_olen    = regs.olen;
    assign out_sfpd    = regs.sfpd;
    assign out_pwmen   = regs.pwmen;
    assign out_andor   = regs.andor;
    assign retry_therm = regs.retry_therm;
    assign resume_ov   = regs.resume_ov;
    assign fault_lat   = t_q.fault;

    // R4: a deselected pin for two synchronizer delays means MISO is released
    p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);
    // R6: the end of a frame wipes every latched fault
    p_clear_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (fault_lat == '0 && !t_q.ov));
    // R12: latched faults never drop without a clear
    p_fault_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rise && !hard_clr) |=> ((fault_lat & $past(fault_lat)) == $past(fault_lat)));
    // R12: a fault input sets its latch in the next cycle
    p_fault_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rise && !hard_clr) |=> ((fault_lat & $past(fault_in)) == $past(fault_in)));
endmodule

// File: tb/test_spi_cmd_status_if.sv
module test_spi_cmd_status_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0, rst_pin_n = 1'b1, supply_uv = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [15:0] fault_in = '0;
    logic ov_in = 1'b0;
    logic [15:0] out_on, out_olen, out_sfpd, out_pwmen, out_andor, fault_lat;
    logic retry_therm, resume_ov;
    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_cmd_status_if i_spi_cmd_status_if (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .supply_uv(supply_uv),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .fault_in(fault_in),
        .ov_in(ov_in), .out_on(out_on), .out_olen(out_olen), .out_sfpd(out_sfpd),
        .out_pwmen(out_pwmen), .out_andor(out_andor), .retry_therm(retry_therm),
        .resume_ov(resume_ov), .fault_lat(fault_lat));

    typedef struct packed {
        logic [23:0] word;
        logic [2:0]  sel;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{24'h00A5C3, 3'd0, 16'hA5C3, 4'd2},
        '{24'h0400FF, 3'd1, 16'h00FF, 4'd2},
        '{24'h0C1234, 3'd2, 16'h1234, 4'd2},
        '{24'h10F00F, 3'd3, 16'hF00F, 4'd2},
        '{24'h148001, 3'd4, 16'h8001, 4'd2},
        '{24'h0A0000, 3'd5, 16'h0002, 4'd7},
        '{24'h09FFFF, 3'd5, 16'h0001, 4'd7},
        '{24'h1CFFFF, 3'd0, 16'hA5C3, 4'd10},
        '{24'hFFFFFF, 3'd3, 16'hF00F, 4'd10},
        '{24'h0A0000, 3'd5, 16'h0002, 4'd7}
    };

    function automatic logic [15:0] reg_sel(input logic [2:0] sel);
        case (sel)
            3'd0: return out_on;
            3'd1: return out_olen;
            3'd2: return out_sfpd;
            3'd3: return out_pwmen;
            3'd4: return out_andor;
            default: return {14'b0, retry_therm, resume_ov};
        endcase
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic oe_seen;

    task automatic spi_xfer(input logic [47:0] tx, input int nbits, output logic [47:0] rx);
        rx = '0;
        oe_seen = 1'b1;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(10);
        for (int k = 1; k <= nbits; k++) begin
            spi_mosi = tx[nbits-k];
            spi_sclk = 1'b1;
            wait_clk(8);
            rx[nbits-k] = spi_miso;
            oe_seen = oe_seen & spi_miso_oe;
            spi_sclk = 1'b0;
            wait_clk(8);
        end
        spi_cs_n = 1'b1;
        wait_clk(10);
    endtask

    logic [47:0] rx;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: reset state
        check("R1 reset on", out_on, 0);
        check("R1 reset olen", out_olen, 0);
        check("R1 reset retry", {retry_therm, resume_ov}, 0);
        check("R4 idle oe", spi_miso_oe, 0);

        // R2 R7 R10: table walk
        for (int v = 0; v < NVEC; v++) begin
            spi_xfer({24'h0, VECS[v].word}, 24, rx);
            checks++;
            if (reg_sel(VECS[v].sel) !== VECS[v].exp) begin
                errors++;
                $display("FAIL R%0d vec %0d actual=%h expected=%h", VECS[v].req, v,
                         reg_sel(VECS[v].sel), VECS[v].exp);
            end
        end
        check("R4 oe during frame", oe_seen, 1);

        // R8: soft reset
        spi_xfer({24'h0, 24'h180000}, 24, rx);
        check("R8 on", out_on, 0);
        check("R8 sfpd", out_sfpd, 0);
        check("R8 pwmen", out_pwmen, 0);
        check("R8 andor", out_andor, 0);
        check("R8 olen kept", out_olen, 16'h00FF);
        check("R8 retry kept", {retry_therm, resume_ov}, 2'b10);

        // R12 R5 R3 R6: fault latch and status readout
        fault_in = 16'h0240;
        ov_in = 1'b1;
        wait_clk(1);
        fault_in = '0;
        ov_in = 1'b0;
        wait_clk(4);
        check("R12 latch held", fault_lat, 16'h0240);
        spi_xfer({24'h0, 24'h1C0000}, 24, rx);
        check("R5 R3 status word", rx[23:0], 24'hC00240);
        check("R6 cleared at end", fault_lat, 0);
        spi_xfer({24'h0, 24'h1C0000}, 24, rx);
        check("R6 next status clear", rx[23:0], 0);

        // R9: 48-bit echo, last word executed
        spi_xfer({24'h1C1234, 24'h140F0F}, 48, rx);
        check("R9 echo", rx[23:0], 24'h1C1234);
        check("R9 last executed", out_andor, 16'h0F0F);

        // R11: long and short frames
        spi_xfer({18'h0, 6'b101101, 24'h003C3C}, 30, rx);
        check("R11 long frame", out_on, 16'h3C3C);
        spi_xfer({32'h0, 16'h0005}, 16, rx);
        check("R11 short frame", out_on, 16'h0005);

        // R4: clocking while deselected
        for (int k = 0; k < 24; k++) begin
            spi_mosi = k[0];
            spi_sclk = 1'b1;
            wait_clk(4);
            check("R4 oe low", spi_miso_oe, 0);
            spi_sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(10);
        check("R4 on unchanged", out_on, 16'h0005);
        check("R4 andor unchanged", out_andor, 16'h0F0F);

        // R1: reset pin
        fault_in = 16'h8000;
        wait_clk(1);
        fault_in = '0;
        rst_pin_n = 1'b0;
        wait_clk(3);
        rst_pin_n = 1'b1;
        wait_clk(2);
        check("R1 pin on", out_on, 0);
        check("R1 pin andor", out_andor, 0);
        check("R1 pin olen", out_olen, 0);
        check("R1 pin faults", fault_lat, 0);

        // R1: undervoltage
        spi_xfer({24'h0, 24'h04ABCD}, 24, rx);
        spi_xfer({24'h0, 24'h0B0000}, 24, rx);
        check("R7 both retry bits", {retry_therm, resume_ov}, 2'b11);
        supply_uv = 1'b1;
        wait_clk(3);
        supply_uv = 1'b0;
        wait_clk(2);
        check("R1 uv olen", out_olen, 0);
        check("R1 uv retry", {retry_therm, resume_ov}, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule